// File: doc/BRIEF.md
# Dual-Port RAM with Collision Arbitration

A synchronous 2048-word by 8-bit memory with two fully independent ports, named left and right. Each port has its own address, write data, read data, chip enable, write enable and output enable, all control inputs active low. Either port can reach any word at any time. When both ports land on the same word in one cycle and at least one of them is writing, an arbiter picks a winner and pulls the loser's active-low busy flag down. The loser's write is dropped in that same cycle, so the word takes only the winner's data.

Two reserved words act as mailboxes between the ports. A write by one port to the other port's mailbox raises that other port's active-low interrupt, and the owner clears it by reading its mailbox. A mode input turns the block into a slave for width expansion. In that mode the busy flags come in from a master device and gate the writes, so several devices side by side behave as one wide word.

Top module: `dpram_arb`

## Requirements
- R1: A write on either port (chip enable low, write enable low) stores the data. A read (chip enable low, write enable high, output enable low) returns the stored word on that port's read data one clock after the access. Reads return the word as it was before the writes of the same cycle.
- R2: When both ports read the same address in the same cycle, neither busy flag goes low and both ports receive the word.
- R3: A collision is both chip enables low, equal addresses and at least one port writing. If neither port was active on that address in the previous cycle, or both were, the left port wins. busy_r_n goes low in that same cycle and the right port's write is not performed.
- R4: If in a collision the right port was active on that address in the previous cycle and the left port was not, the right port keeps the word. busy_l_n goes low and the left port's write is not performed.
- R5: In master mode the two busy flags are never low at the same time.
- R6: A performed right-port write to address 0x7FF drives int_l_n low from the next cycle. A left-port read of 0x7FF drives it high again from the next cycle.
- R7: A performed left-port write to address 0x7FE drives int_r_n low from the next cycle. A right-port read of 0x7FE drives it high again from the next cycle.
- R8: With slave_en high, both busy outputs stay high and the internal arbiter blocks nothing. A low busy_in_l_n or busy_in_r_n drops that port's write for the cycle. If both ports write one address unblocked, the left data is kept.
- R9: With chip enable high, a port writes nothing and its read data is 0 on the next cycle. A read with output enable high also gives 0 on the next cycle.
- R10: After reset, both read data outputs are 0, both interrupt flags are high, and with idle ports both busy flags are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| slave_en | input | 1 | 1 = slave mode, busy taken from inputs |
| l_ce_n | input | 1 | Left chip enable, active low |
| l_we_n | input | 1 | Left write enable, active low |
| l_oe_n | input | 1 | Left output enable, active low |
| l_addr | input | 11 | Left address |
| l_din | input | 8 | Left write data |
| l_dout | output | 8 | Left read data, registered |
| busy_in_l_n | input | 1 | Left busy from master (slave mode) |
| busy_l_n | output | 1 | Left busy flag, active low |
| int_l_n | output | 1 | Left mailbox interrupt, active low |
| r_ce_n | input | 1 | Right chip enable, active low |
| r_we_n | input | 1 | Right write enable, active low |
| r_oe_n | input | 1 | Right output enable, active low |
| r_addr | input | 11 | Right address |
| r_din | input | 8 | Right write data |
| r_dout | output | 8 | Right read data, registered |
| busy_in_r_n | input | 1 | Right busy from master (slave mode) |
| busy_r_n | output | 1 | Right busy flag, active low |
| int_r_n | output | 1 | Right mailbox interrupt, active low |

## Verification
The assertions watch the properties that can be judged in any cycle. They check that both busy flags are never low together in master mode and that shared reads raise no busy. They also check that a disabled port returns idle data and that mailbox writes and reads move the interrupt flags one cycle later. Which port wins, and whether the losing or gated write really left the word untouched, appears only in the bench scenarios. Those scenarios read the words back: same-cycle write collisions, a write racing a read, a port already holding an address, and slave writes gated by an incoming busy.

// File: rtl/dpram_arb.sv
module dpram_arb #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slave_en,
  input  logic              l_ce_n,
  input  logic              l_we_n,
  input  logic              l_oe_n,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_din,
  output logic [DATA_W-1:0] l_dout,
  input  logic              busy_in_l_n,
  output logic              busy_l_n,
  output logic              int_l_n,
  input  logic              r_ce_n,
  input  logic              r_we_n,
  input  logic              r_oe_n,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_din,
  output logic [DATA_W-1:0] r_dout,
  input  logic              busy_in_r_n,
  output logic              busy_r_n,
  output logic              int_r_n
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] MBOX_L = '1;
  localparam logic [ADDR_W-1:0] MBOX_R = MBOX_L - 1'b1;

  logic [DATA_W-1:0] mem [DEPTH];

  logic l_en, r_en, l_rd, r_rd, l_wq, r_wq;
  assign l_en = ~l_ce_n;
  assign r_en = ~r_ce_n;
  assign l_rd = l_en & l_we_n;
  assign r_rd = r_en & r_we_n;
  assign l_wq = l_en & ~l_we_n;
  assign r_wq = r_en & ~r_we_n;

  logic              pl_en, pr_en;
  logic [ADDR_W-1:0] pl_addr, pr_addr;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pl_en <= 1'b0;
      pr_en <= 1'b0;
      pl_addr <= '0;
      pr_addr <= '0;
    end else begin
      pl_en <= l_en;
      pr_en <= r_en;
      pl_addr <= l_addr;
      pr_addr <= r_addr;
    end
  end

  logic coll, l_held, r_held, left_wins, l_lose, r_lose;
  assign coll      = l_en & r_en & (l_addr == r_addr) & (l_wq | r_wq);
  assign l_held    = pl_en & (pl_addr == l_addr);
  assign r_held    = pr_en & (pr_addr == r_addr);
  assign left_wins = ~(r_held & ~l_held);
  assign l_lose    = coll & ~left_wins;
  assign r_lose    = coll & left_wins;

  assign busy_l_n = slave_en | ~l_lose;
  assign busy_r_n = slave_en | ~r_lose;

  logic l_block, r_block, l_wr, r_wr;
  assign l_block = slave_en ? ~busy_in_l_n : l_lose;
  assign r_block = slave_en ? ~busy_in_r_n : r_lose;
  assign l_wr    = l_wq & ~l_block;
  assign r_wr    = r_wq & ~r_block;

  always_ff @(posedge clk) begin
    if (r_wr) mem[r_addr] <= r_din;
    if (l_wr) mem[l_addr] <= l_din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l_dout <= '0;
      r_dout <= '0;
    end else begin
      l_dout <= (l_rd & ~l_oe_n) ? mem[l_addr] : '0;
      r_dout <= (r_rd & ~r_oe_n) ? mem[r_addr] : '0;
    end
  end

  logic set_l, clr_l, set_r, clr_r, pend_l, pend_r;
  assign set_l = r_wr & (r_addr == MBOX_L);
  assign clr_l = l_rd & (l_addr == MBOX_L);
  assign set_r = l_wr & (l_addr == MBOX_R);
  assign clr_r = r_rd & (r_addr == MBOX_R);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_l <= 1'b0;
      pend_r <= 1'b0;
    end else begin
      if (set_l) pend_l <= 1'b1;
      else if (clr_l) pend_l <= 1'b0;
      if (set_r) pend_r <= 1'b1;
      else if (clr_r) pend_r <= 1'b0;
    end
  end

  assign int_l_n = ~pend_l;
  assign int_r_n = ~pend_r;

  p_one_loser_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !slave_en |-> (busy_l_n || busy_r_n));

  p_shared_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!slave_en && !l_ce_n && !r_ce_n && l_we_n && r_we_n) |-> (busy_l_n && busy_r_n));

  p_idle_left_r9: assert property (@(posedge clk) disable iff (!rst_n)
    l_ce_n |=> (l_dout == '0));

  p_idle_right_r9: assert property (@(posedge clk) disable iff (!rst_n)
    r_ce_n |=> (r_dout == '0));

  p_int_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!r_ce_n && !r_we_n && r_addr == MBOX_L && !r_block) |=> !int_l_n);

  p_int_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!l_ce_n && l_we_n && l_addr == MBOX_L && !set_l) |=> int_l_n);

  p_int_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!l_ce_n && !l_we_n && l_addr == MBOX_R && !l_block) |=> !int_r_n);

  p_int_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!r_ce_n && r_we_n && r_addr == MBOX_R && !set_r) |=> int_r_n);
endmodule

// File: tb/dpram_arb_tb.sv
module dpram_arb_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic slave_en = 1'b0;
  logic l_ce_n, l_we_n, l_oe_n, r_ce_n, r_we_n, r_oe_n;
  logic [10:0] l_addr, r_addr;
  logic [7:0] l_din, r_din, l_dout, r_dout;
  logic busy_in_l_n = 1'b1, busy_in_r_n = 1'b1;
  logic busy_l_n, busy_r_n, int_l_n, int_r_n;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dpram_arb u_dut (
    .clk(clk), .rst_n(rst_n), .slave_en(slave_en),
    .l_ce_n(l_ce_n), .l_we_n(l_we_n), .l_oe_n(l_oe_n), .l_addr(l_addr),
    .l_din(l_din), .l_dout(l_dout), .busy_in_l_n(busy_in_l_n),
    .busy_l_n(busy_l_n), .int_l_n(int_l_n),
    .r_ce_n(r_ce_n), .r_we_n(r_we_n), .r_oe_n(r_oe_n), .r_addr(r_addr),
    .r_din(r_din), .r_dout(r_dout), .busy_in_r_n(busy_in_r_n),
    .busy_r_n(busy_r_n), .int_r_n(int_r_n)
  );

  // port word: {ce_n, we_n, oe_n, addr[10:0], din[7:0]}
  function automatic logic [21:0] pw(input logic [10:0] a, input logic [7:0] d);
    return {3'b001, a, d};
  endfunction
  function automatic logic [21:0] pr(input logic [10:0] a);
    return {3'b010, a, 8'h00};
  endfunction
  function automatic logic [21:0] pro(input logic [10:0] a);
    return {3'b011, a, 8'h00};
  endfunction
  function automatic logic [21:0] pcw(input logic [10:0] a, input logic [7:0] d);
    return {3'b101, a, d};
  endfunction
  function automatic logic [21:0] pi();
    return {3'b111, 11'h000, 8'h00};
  endfunction

  // vector: {req[3:0], left[21:0], right[21:0], busy_l, busy_r, l_dout, r_dout}
  localparam int NV = 17;
  localparam logic [65:0] VEC [NV] = '{
    {4'd1,  pw(11'h010, 8'hA5), pi(),               1'b1, 1'b1, 8'h00, 8'h00}, // R1
    {4'd1,  pi(),               pw(11'h020, 8'h3C), 1'b1, 1'b1, 8'h00, 8'h00}, // R1
    {4'd1,  pr(11'h020),        pr(11'h010),        1'b1, 1'b1, 8'h3C, 8'hA5}, // R1
    {4'd2,  pr(11'h010),        pr(11'h010),        1'b1, 1'b1, 8'hA5, 8'hA5}, // R2
    {4'd9,  pi(),               pi(),               1'b1, 1'b1, 8'h00, 8'h00}, // R9
    {4'd3,  pw(11'h030, 8'h11), pw(11'h030, 8'h22), 1'b1, 1'b0, 8'h00, 8'h00}, // R3
    {4'd9,  pi(),               pi(),               1'b1, 1'b1, 8'h00, 8'h00}, // R9
    {4'd3,  pr(11'h030),        pr(11'h030),        1'b1, 1'b1, 8'h11, 8'h11}, // R3
    {4'd3,  pw(11'h010, 8'h5A), pr(11'h010),        1'b1, 1'b0, 8'h00, 8'hA5}, // R3 race
    {4'd1,  pr(11'h010),        pi(),               1'b1, 1'b1, 8'h5A, 8'h00}, // R1
    {4'd4,  pi(),               pw(11'h050, 8'h66), 1'b1, 1'b1, 8'h00, 8'h00}, // R4
    {4'd4,  pw(11'h050, 8'h99), pw(11'h050, 8'h67), 1'b0, 1'b1, 8'h00, 8'h00}, // R4
    {4'd9,  pi(),               pi(),               1'b1, 1'b1, 8'h00, 8'h00}, // R9
    {4'd4,  pr(11'h050),        pi(),               1'b1, 1'b1, 8'h67, 8'h00}, // R4
    {4'd9,  pro(11'h050),       pi(),               1'b1, 1'b1, 8'h00, 8'h00}, // R9
    {4'd9,  pcw(11'h050, 8'hFF), pi(),              1'b1, 1'b1, 8'h00, 8'h00}, // R9
    {4'd9,  pr(11'h050),        pr(11'h050),        1'b1, 1'b1, 8'h67, 8'h67}  // R9
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [21:0] lp, input logic [21:0] rp);
    {l_ce_n, l_we_n, l_oe_n, l_addr, l_din} = lp;
    {r_ce_n, r_we_n, r_oe_n, r_addr, r_din} = rp;
  endtask

  // drive at negedge, let one posedge pass, land on the next negedge
  task automatic step(input logic [21:0] lp, input logic [21:0] rp);
    apply(lp, rp);
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    apply(pi(), pi());
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 l_dout", l_dout, 8'h00);
    chk("R10 r_dout", r_dout, 8'h00);
    chk("R10 int_l_n", {7'd0, int_l_n}, 8'h01);
    chk("R10 int_r_n", {7'd0, int_r_n}, 8'h01);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 busy_l_n", {7'd0, busy_l_n}, 8'h01);
    chk("R10 busy_r_n", {7'd0, busy_r_n}, 8'h01);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d step %0d", VEC[i][65:62], i);
      apply(VEC[i][61:40], VEC[i][39:18]);
      #1;
      chk({tag, " busy_l_n"}, {7'd0, busy_l_n}, {7'd0, VEC[i][17]});
      chk({tag, " busy_r_n"}, {7'd0, busy_r_n}, {7'd0, VEC[i][16]});
      @(negedge clk);
      chk({tag, " l_dout"}, l_dout, VEC[i][15:8]);
      chk({tag, " r_dout"}, r_dout, VEC[i][7:0]);
    end

    // R6 left mailbox
    step(pi(), pw(11'h7FF, 8'hC3));
    chk("R6 int_l_n set", {7'd0, int_l_n}, 8'h00);
    chk("R6 int_r_n untouched", {7'd0, int_r_n}, 8'h01);
    step(pr(11'h7FF), pi());
    chk("R6 int_l_n cleared", {7'd0, int_l_n}, 8'h01);
    chk("R6 mailbox data", l_dout, 8'hC3);

    // R7 right mailbox
    step(pw(11'h7FE, 8'h3A), pi());
    chk("R7 int_r_n set", {7'd0, int_r_n}, 8'h00);
    chk("R7 int_l_n untouched", {7'd0, int_l_n}, 8'h01);
    step(pi(), pr(11'h7FE));
    chk("R7 int_r_n cleared", {7'd0, int_r_n}, 8'h01);
    chk("R7 mailbox data", r_dout, 8'h3A);

    // R8 slave mode
    slave_en = 1'b1;
    step(pw(11'h060, 8'h34), pi());
    busy_in_l_n = 1'b0;
    apply(pw(11'h060, 8'h12), pi());
    #1;
    chk("R8 busy_l_n held high", {7'd0, busy_l_n}, 8'h01);
    @(negedge clk);
    busy_in_l_n = 1'b1;
    step(pr(11'h060), pi());
    chk("R8 blocked write", l_dout, 8'h34);
    apply(pw(11'h070, 8'hAA), pw(11'h070, 8'hBB));
    #1;
    chk("R8 busy_r_n no arbitration", {7'd0, busy_r_n}, 8'h01);
    @(negedge clk);
    step(pi(), pi());
    step(pr(11'h070), pr(11'h070));
    chk("R8 left kept l", l_dout, 8'hAA);
    chk("R8 left kept r", r_dout, 8'hAA);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule